// File: doc/BRIEF.md
# HD Video Line CRC Inserter

This block sits in the transmit path of a high-definition serial digital video link. It takes the parallel stream before channel coding: one 10-bit luma word and one 10-bit chroma word per clock. It computes an 18-bit line checksum for each channel and writes the result into the two check-word slots that carry it. Upstream logic has already placed the timing reference sequences and the line-number words in the stream. The only marker the block receives is a strobe on the first word (the all-ones word) of every timing reference sequence.

The fourth word of each timing reference sequence is the status word, and its bit 6 separates end-of-active-video (1) from start-of-active-video (0). A start status word opens a checksum window and clears both checksum registers. The window covers every word from the first active sample through the end sequence and both line-number words. The two words that follow are replaced by the formatted checksum. Every other word leaves the block unchanged, one clock after it entered.

Top module: `hd_line_crc_inserter`

## Requirements
- R1: Each channel's checksum uses the generator x^18 + x^5 + x^4 + 1 and starts from zero. Each 10-bit word is folded in one bit at a time, bit 0 first.
- R2: A status word with bit 6 = 0 clears the checksum. The window then opens on the next word, which is the first active word.
- R3: The window includes the four end-sequence words and the two line-number words that follow them. It closes after the second line-number word.
- R4: The two words after the second line-number word are replaced. The first becomes {~c[8], c[8:0]} and the second becomes {~c[17], c[17:9]}, where c is that channel's checksum.
- R5: The luma and chroma checksums are computed and inserted independently, in the same cycles.
- R6: Every word outside the two check slots appears at the output unchanged, exactly one clock after it was presented.
- R7: An end status word (bit 6 = 1) that arrives while no window is open causes no insertion. The words after it pass through.
- R8: The status word is the word presented exactly three clocks after the strobe. The strobe marks word 0 of the sequence.
- R9: While reset is held and after it is released, both outputs read zero until the first word is clocked through.
- R10: Blanking words between the check slots and the next start sequence do not affect the next line's checksum.
- R11: A start status word that arrives while a window is open restarts the checksum. Words before it are not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trs_in | input | 1 | High on word 0 of every timing reference sequence |
| y_in | input | 10 | Luma word in |
| c_in | input | 10 | Chroma word in |
| y_out | output | 10 | Luma word out, with check words inserted |
| c_out | output | 10 | Chroma word out, with check words inserted |

## Verification
The active-line length is swept from one word to two dozen words, and each length is tried with five content patterns:
- All-zero and all-ones content separate a wrong initial value from a wrong feedback tap.
- A walking single bit exposes a bit order that is reversed or offset within the word.
- Pseudo-random content with different luma and chroma values catches crossed channels.
- A pattern with constant chroma and varying luma checks that the two channels stay independent.

Blanking words of varying content and length show that nothing outside the window leaks into the checksum. A stray end sequence with no window open, and a start sequence repeated mid-line, exercise the window control on its own.

// File: rtl/hdcrc_pkg.sv
package hdcrc_pkg;

  localparam int WORD_W = 10;
  localparam int CRC_W  = 18;
  localparam int HALF_W = CRC_W / 2;
  localparam int LANES  = 2;
  localparam int H_BIT  = 6;

  // generator terms below x^18: x^5 + x^4 + 1
  localparam logic [CRC_W-1:0] GEN_LOW = 18'h00031;

  typedef enum logic [2:0] {
    TL_IDLE,
    TL_LN0,
    TL_LN1,
    TL_CR0,
    TL_CR1
  } tail_t;

  // mirror the generator for a right-shifting, LSB-first register
  function automatic logic [CRC_W-1:0] mirror_gen(input logic [CRC_W-1:0] g);
    logic [CRC_W-1:0] m;
    m = '0;
    for (int k = 0; k < CRC_W; k++) begin
      m[CRC_W-1-k] = g[k];
    end
    return m;
  endfunction

  localparam logic [CRC_W-1:0] GEN_MIR = mirror_gen(GEN_LOW);

  // fold one word into the running checksum, bit 0 first
  function automatic logic [CRC_W-1:0] crc_fold(input logic [CRC_W-1:0] c,
                                                input logic [WORD_W-1:0] d);
    logic [CRC_W-1:0] r;
    logic             fb;
    r = c;
    for (int i = 0; i < WORD_W; i++) begin
      fb = r[0] ^ d[i];
      r  = r >> 1;
      if (fb) r = r ^ GEN_MIR;
    end
    return r;
  endfunction

  // a half checksum as a legal video word: top bit is the inverse of the next
  function automatic logic [WORD_W-1:0] slot_word(input logic [HALF_W-1:0] h);
    return {~h[HALF_W-1], h};
  endfunction

endpackage

// File: rtl/hdcrc_frame_tracker.sv
module hdcrc_frame_tracker
  import hdcrc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic trs_in,
  input  logic h_flag,
  output logic acc_en,
  output logic crc_clr,
  output logic ins_lo,
  output logic ins_hi
);

  logic [1:0] tcnt;
  tail_t      tail;
  logic       win_open;

  // event wires brought out for checks
  logic xyz_now;
  logic sav_xyz;
  logic eav_xyz;

  assign xyz_now = (tcnt == 2'd3) && !trs_in;
  assign sav_xyz = xyz_now && !h_flag;
  assign eav_xyz = xyz_now && h_flag && win_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt <= 2'd0;
    end else if (trs_in) begin
      tcnt <= 2'd1;
    end else if (tcnt != 2'd0) begin
      tcnt <= tcnt + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tail <= TL_IDLE;
    end else if (eav_xyz) begin
      tail <= TL_LN0;
    end else begin
      case (tail)
        TL_LN0:  tail <= TL_LN1;
        TL_LN1:  tail <= TL_CR0;
        TL_CR0:  tail <= TL_CR1;
        default: tail <= TL_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_open <= 1'b0;
    end else if (sav_xyz) begin
      win_open <= 1'b1;
    end else if (tail == TL_LN1) begin
      win_open <= 1'b0;
    end
  end

  assign acc_en  = win_open;
  assign crc_clr = sav_xyz;
  assign ins_lo  = (tail == TL_CR0);
  assign ins_hi  = (tail == TL_CR1);

  // R8
  xyz_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xyz_now |-> $past(trs_in, 3));

  // R2
  win_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sav_xyz |=> win_open);

  // R3
  win_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tail == TL_LN1 && !sav_xyz) |=> !win_open);

  // R4
  slot_follows_eav_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eav_xyz |-> ##3 ins_lo);

  // R7
  no_slot_when_shut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xyz_now && h_flag && !win_open && tail == TL_IDLE) |=> (tail == TL_IDLE));

endmodule

// File: rtl/hdcrc_lane_accum.sv
module hdcrc_lane_accum
  import hdcrc_pkg::*;
#(
  parameter int DW = WORD_W,
  parameter int CW = CRC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_en,
  input  logic          crc_clr,
  input  logic [DW-1:0] d_in,
  output logic [CW-1:0] crc
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc <= '0;
    end else if (crc_clr) begin
      crc <= '0;
    end else if (acc_en) begin
      crc <= crc_fold(crc, d_in);
    end
  end

  // R1
  clear_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crc_clr |=> (crc == '0));

  // R10
  hold_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_en && !crc_clr) |=> $stable(crc));

endmodule

// File: rtl/hdcrc_slot_mux.sv
module hdcrc_slot_mux
  import hdcrc_pkg::*;
#(
  parameter int DW = WORD_W,
  parameter int CW = CRC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ins_lo,
  input  logic          ins_hi,
  input  logic [DW-1:0] d_in,
  input  logic [CW-1:0] crc,
  output logic [DW-1:0] d_out
);

  localparam int HW = CW / 2;

  logic [DW-1:0] lo_word;
  logic [DW-1:0] hi_word;

  assign lo_word = slot_word(crc[HW-1:0]);
  assign hi_word = slot_word(crc[CW-1:HW]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_out <= '0;
    end else if (ins_lo) begin
      d_out <= lo_word;
    end else if (ins_hi) begin
      d_out <= hi_word;
    end else begin
      d_out <= d_in;
    end
  end

  // R6
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ins_lo && !ins_hi) |=> (d_out == $past(d_in)));

  // R4
  slot_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_lo || ins_hi) |=> (d_out[DW-1] != d_out[DW-2]));

  // R4
  slot_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ins_lo, ins_hi}));

endmodule

// File: rtl/hd_line_crc_inserter.sv
module hd_line_crc_inserter
  import hdcrc_pkg::*;
#(
  parameter int DW    = WORD_W,
  parameter int CW    = CRC_W,
  parameter int NLANE = LANES,
  parameter int HBIT  = H_BIT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trs_in,
  input  logic [DW-1:0] y_in,
  input  logic [DW-1:0] c_in,
  output logic [DW-1:0] y_out,
  output logic [DW-1:0] c_out
);

  logic acc_en;
  logic crc_clr;
  logic ins_lo;
  logic ins_hi;

  logic [DW-1:0] lane_in  [NLANE];
  logic [DW-1:0] lane_out [NLANE];
  logic [CW-1:0] lane_crc [NLANE];

  assign lane_in[0] = y_in;
  assign lane_in[1] = c_in;
  assign y_out      = lane_out[0];
  assign c_out      = lane_out[1];

  hdcrc_frame_tracker u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .trs_in  (trs_in),
    .h_flag  (y_in[HBIT]),
    .acc_en  (acc_en),
    .crc_clr (crc_clr),
    .ins_lo  (ins_lo),
    .ins_hi  (ins_hi)
  );

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    hdcrc_lane_accum #(.DW(DW), .CW(CW)) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .acc_en  (acc_en),
      .crc_clr (crc_clr),
      .d_in    (lane_in[g]),
      .crc     (lane_crc[g])
    );

    hdcrc_slot_mux #(.DW(DW), .CW(CW)) u_mux (
      .clk    (clk),
      .rst_n  (rst_n),
      .ins_lo (ins_lo),
      .ins_hi (ins_hi),
      .d_in   (lane_in[g]),
      .crc    (lane_crc[g]),
      .d_out  (lane_out[g])
    );
  end

  // R5
  lanes_in_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_lo |=> ins_hi);

endmodule

// File: tb/hd_line_crc_inserter_tb.sv
module hd_line_crc_inserter_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       trs_in = 1'b0;
  logic [9:0] y_in = '0;
  logic [9:0] c_in = '0;
  logic [9:0] y_out;
  logic [9:0] c_out;

  int n_run  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hd_line_crc_inserter dut_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .trs_in (trs_in),
    .y_in   (y_in),
    .c_in   (c_in),
    .y_out  (y_out),
    .c_out  (c_out)
  );

  // bit-serial model written as explicit per-bit register moves
  function automatic logic [17:0] ref_fold(input logic [17:0] c, input logic [9:0] d);
    logic [17:0] r;
    logic [17:0] n;
    logic        fb;
    r = c;
    for (int i = 0; i < 10; i++) begin
      fb = d[i] ^ r[0];
      for (int k = 0; k < 17; k++) n[k] = r[k+1];
      n[17] = fb;
      n[13] = r[14] ^ fb;
      n[12] = r[13] ^ fb;
      r = n;
    end
    return r;
  endfunction

  function automatic logic [9:0] pat_word(input int pat, input int i, input int ch);
    case (pat)
      0:       return 10'h000;
      1:       return 10'h3FF;
      2:       return 10'(1 << ((i + 3*ch) % 10));
      3:       return 10'((i*37 + ch*101 + 11) & 10'h3FF);
      default: return ch ? 10'h040 : 10'((i*13 + 5) & 10'h3FF);
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [9:0] act,
                     input logic [9:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  // drive at a falling edge, check the word one clock later at the next falling edge
  task automatic step(input logic [9:0] y, input logic [9:0] c, input logic t,
                      input logic [9:0] ey, input logic [9:0] ec, input string req);
    y_in = y; c_in = c; trs_in = t;
    @(posedge clk);
    @(negedge clk);
    chk(req, "luma", y_out, ey);
    chk(req, "chroma", c_out, ec);
  endtask

  task automatic pass(input logic [9:0] y, input logic [9:0] c, input logic t,
                      input string req);
    step(y, c, t, y, c, req);
  endtask

  task automatic sav_seq();
    pass(10'h3FF, 10'h3FF, 1'b1, "R8");
    pass(10'h000, 10'h000, 1'b0, "R8");
    pass(10'h000, 10'h000, 1'b0, "R8");
    pass(10'h200, 10'h200, 1'b0, "R2");
  endtask

  task automatic send_line(input int n_act, input int pat, input int n_blank,
                           input bit with_sav);
    logic [17:0] cy;
    logic [17:0] cc;
    logic [9:0]  w_y;
    logic [9:0]  w_c;
    logic [9:0]  tail_w [6];
    cy = '0;
    cc = '0;
    for (int b = 0; b < n_blank; b++) begin
      pass(10'((b*71 + pat*29 + 3) & 10'h3FF), 10'((b*53 + 200) & 10'h3FF), 1'b0, "R10");
    end
    if (with_sav) sav_seq();
    for (int i = 0; i < n_act; i++) begin
      w_y = pat_word(pat, i, 0);
      w_c = pat_word(pat, i, 1);
      cy  = ref_fold(cy, w_y);
      cc  = ref_fold(cc, w_c);
      pass(w_y, w_c, 1'b0, "R6");
    end
    tail_w[0] = 10'h3FF; tail_w[1] = 10'h000; tail_w[2] = 10'h000;
    tail_w[3] = 10'h274; tail_w[4] = 10'(10'h200 | (n_act & 10'h07F));
    tail_w[5] = 10'h220;
    for (int j = 0; j < 6; j++) begin
      cy = ref_fold(cy, tail_w[j]);
      cc = ref_fold(cc, tail_w[j]);
      pass(tail_w[j], tail_w[j], (j == 0), "R3");
    end
    step(10'h155, 10'h155, 1'b0, {~cy[8], cy[8:0]}, {~cc[8], cc[8:0]}, "R1 R4 R5");
    step(10'h2AA, 10'h2AA, 1'b0, {~cy[17], cy[17:9]}, {~cc[17], cc[17:9]}, "R1 R4 R5");
    pass(10'h155, 10'h2AA, 1'b0, "R6");
  endtask

  task automatic stray_eav();
    pass(10'h3FF, 10'h3FF, 1'b1, "R7");
    pass(10'h000, 10'h000, 1'b0, "R7");
    pass(10'h000, 10'h000, 1'b0, "R7");
    pass(10'h274, 10'h274, 1'b0, "R7");
    for (int k = 0; k < 5; k++) pass(10'(10'h111 + k), 10'(10'h0F0 + k), 1'b0, "R7");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk("R9", "luma in reset", y_out, 10'h000);
    chk("R9", "chroma in reset", c_out, 10'h000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", "luma after reset", y_out, 10'h000);
    chk("R9", "chroma after reset", c_out, 10'h000);

    // R7: end sequence with no window open
    stray_eav();

    // R1 R4 R5 R6 R10: sweep of lengths and patterns
    for (int n = 1; n <= 24; n++) begin
      for (int p = 0; p < 5; p++) begin
        send_line(n, p, (n + p) % 6, 1'b1);
      end
    end

    // R7 again, after a finished line
    stray_eav();

    // R11: start sequence repeated inside an open window
    sav_seq();
    for (int k = 0; k < 3; k++) pass(10'(10'h3A0 + k), 10'(10'h05A + k), 1'b0, "R11");
    send_line(9, 3, 0, 1'b1);
    sav_seq();
    send_line(4, 2, 0, 1'b1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule